// File: doc/BRIEF.md
# Instruction completion interrupt sequencer

This block runs the command handshake between a peripheral controller and its host. While idle it holds a function-ready line high and takes one instruction code. Read and write instructions hand off to a data path and wait for it to report completion. Every operational instruction then raises an interrupt with a two-bit completion code, and the block returns to ready once the host acknowledges.

The two status-request instructions are the exception: they put a parity-error count or an overrun count on a response bus for one cycle and raise no interrupt. Master clear and terminate can also be forced in while ready is low, which aborts a running transfer. Master clear wipes both error counts but leaves the memory-protect register alone. Terminate leaves every count as it was.

Top module: `icseq_top`

## Requirements
- R1: While reset is active and in the first cycle after it, fn_rdy=1, irq=0, rsp_valid=0, abort=0, prot_q=0, and both error counts are 0.
- R2: A command is taken only when cmd_valid=1 and fn_rdy=1, except that master clear (code 4'h3) and terminate (code 4'h4) with cmd_force=1 are taken in any state. A command that is not taken has no effect. Codes outside 4'h1..4'h7 have no effect.
- R3: Read (4'h1) or write (4'h2) drops fn_rdy on the next cycle and waits for op_done. After op_done, irq=1 from the next cycle with stat_code 2'b01 if par_err was seen during the instruction, and 2'b00 otherwise.
- R4: ack while irq=1 gives irq=0 and fn_rdy=1 on the next cycle. ack while irq=0 has no effect.
- R5: stat_code does not change while irq stays high, unless a forced master clear or terminate is taken.
- R6: Master clear raises irq with stat_code 2'b00 on the next cycle and clears both error counts. It leaves prot_q unchanged.
- R7: Terminate raises irq with stat_code 2'b10 on the next cycle and leaves both error counts unchanged. Taken during an interrupt, it replaces the pending code with 2'b10.
- R8: A parity request (4'h5) or error-count request (4'h6) gives rsp_valid=1 for one cycle on the next cycle, with the parity count or the overrun count zero-extended on rsp_data. fn_rdy stays 1 and no interrupt is raised.
- R9: Each cycle with par_err=1 while an instruction runs adds one to the parity count. Each cycle with overrun=1 while an instruction runs adds one to the overrun count. Both counts saturate at 2^CNT_W-1.
- R10: Set-protect (4'h7) loads cmd_arg into prot_q on the next cycle and raises irq with stat_code 2'b00. Nothing else changes prot_q.
- R11: fn_rdy and irq are never high together. abort pulses for exactly one cycle, only when master clear or terminate is taken during a running instruction, and it coincides with irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction code present |
| cmd_force | input | 1 | Forced function request |
| cmd_code | input | 4 | Instruction code |
| cmd_arg | input | PROT_W | Operand for set-protect |
| op_done | input | 1 | Data path reports transfer finished |
| par_err | input | 1 | Parity error seen this cycle |
| overrun | input | 1 | Overrun seen this cycle |
| ack | input | 1 | Host interrupt acknowledge |
| fn_rdy | output | 1 | Ready for a function |
| irq | output | 1 | Interrupt to the host |
| stat_code | output | 2 | Completion status code |
| abort | output | 1 | One-cycle abort to the data path |
| rsp_valid | output | 1 | Status response strobe |
| rsp_data | output | DATA_W | Status response data |
| prot_q | output | PROT_W | Memory-protect register |

## Verification
Every result is due exactly one clock edge after the input that causes it. A command or ack held through one rising edge shows its effect on irq, fn_rdy, stat_code, abort, rsp_valid, rsp_data and prot_q right after that edge. The counts add par_err and overrun pulses on that same edge and are read back later through a status request. The bench drives inputs on falling edges and samples on the next falling edge, so every sample sees the state left by exactly one rising edge.

// File: rtl/icseq_pkg.sv
package icseq_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_IRQ   = 2'd2
  } seq_state_e;

  localparam logic [3:0] CMD_READ     = 4'h1;
  localparam logic [3:0] CMD_WRITE    = 4'h2;
  localparam logic [3:0] CMD_MCLR     = 4'h3;
  localparam logic [3:0] CMD_TERM     = 4'h4;
  localparam logic [3:0] CMD_SREQ_PAR = 4'h5;
  localparam logic [3:0] CMD_SREQ_ERR = 4'h6;
  localparam logic [3:0] CMD_SETPROT  = 4'h7;

  localparam logic [1:0] STAT_NORMAL = 2'b00;
  localparam logic [1:0] STAT_PARITY = 2'b01;
  localparam logic [1:0] STAT_TERM   = 2'b10;

  typedef struct packed {
    logic op;
    logic mclr;
    logic term;
    logic sreq_par;
    logic sreq_err;
    logic setprot;
  } cmd_acc_t;

endpackage

// File: rtl/icseq_rst_sync.sv
module icseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/icseq_decode.sv
module icseq_decode
  import icseq_pkg::*;
(
  input  logic       cmd_valid,
  input  logic       cmd_force,
  input  logic [3:0] cmd_code,
  input  logic       in_ready,
  output cmd_acc_t   acc
);
  logic ok_norm;
  logic ok_force;
  logic is_rw;

  always_comb begin
    ok_norm  = cmd_valid && in_ready;
    ok_force = cmd_valid && cmd_force;
    is_rw    = (cmd_code == CMD_READ) || (cmd_code == CMD_WRITE);
    acc.op       = ok_norm && is_rw;
    acc.mclr     = (ok_norm || ok_force) && (cmd_code == CMD_MCLR);
    acc.term     = (ok_norm || ok_force) && (cmd_code == CMD_TERM);
    acc.sreq_par = ok_norm && (cmd_code == CMD_SREQ_PAR);
    acc.sreq_err = ok_norm && (cmd_code == CMD_SREQ_ERR);
    acc.setprot  = ok_norm && (cmd_code == CMD_SETPROT);
  end
endmodule

// File: rtl/icseq_satcnt.sv
module icseq_satcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && !(&cnt_q));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icseq_fsm.sv
module icseq_fsm
  import icseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_acc_t   acc,
  input  logic       op_done,
  input  logic       par_err,
  input  logic       ack,
  output seq_state_e state_o,
  output logic [1:0] code_o,
  output logic       abort_o
);
  seq_state_e state_q, state_d;
  logic [1:0] code_q, code_d;
  logic       code_en;
  logic       par_q, par_d;
  logic       abort_q, abort_d;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    code_en = 1'b0;
    par_d   = par_q;
    abort_d = 1'b0;
    unique case (state_q)
      ST_READY: begin
        if (acc.op) begin
          state_d = ST_BUSY;
          par_d   = 1'b0;
        end else if (acc.mclr || acc.setprot) begin
          state_d = ST_IRQ;
          code_d  = STAT_NORMAL;
          code_en = 1'b1;
        end else if (acc.term) begin
          state_d = ST_IRQ;
          code_d  = STAT_TERM;
          code_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (par_err) par_d = 1'b1;
        if (acc.mclr || acc.term) begin
          state_d = ST_IRQ;
          code_d  = acc.mclr ? STAT_NORMAL : STAT_TERM;
          code_en = 1'b1;
          abort_d = 1'b1;
        end else if (op_done) begin
          state_d = ST_IRQ;
          code_d  = (par_q || par_err) ? STAT_PARITY : STAT_NORMAL;
          code_en = 1'b1;
        end
      end
      ST_IRQ: begin
        if (acc.mclr || acc.term) begin
          code_d  = acc.mclr ? STAT_NORMAL : STAT_TERM;
          code_en = 1'b1;
        end else if (ack) begin
          state_d = ST_READY;
        end
      end
      default: state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      code_q  <= STAT_NORMAL;
      par_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      par_q   <= par_d;
      abort_q <= abort_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign state_o = state_q;
  assign code_o  = code_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/icseq_top.sv
module icseq_top
  import icseq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int PROT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_force,
  input  logic [3:0]        cmd_code,
  input  logic [PROT_W-1:0] cmd_arg,
  input  logic              op_done,
  input  logic              par_err,
  input  logic              overrun,
  input  logic              ack,
  output logic              fn_rdy,
  output logic              irq,
  output logic [1:0]        stat_code,
  output logic              abort,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [PROT_W-1:0] prot_q
);
  localparam int PAD_W  = DATA_W - CNT_W;
  localparam int N_CNT  = 2;
  localparam int IX_PAR = 0;
  localparam int IX_OVR = 1;

  logic       rst_sync_n;
  cmd_acc_t   acc;
  seq_state_e state;
  logic       in_ready;
  logic       running;

  logic [CNT_W-1:0] cnt_v [N_CNT];
  logic [N_CNT-1:0] inc_v;

  logic              rsp_v_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [PROT_W-1:0] prot_r;

  icseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  icseq_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_force (cmd_force),
    .cmd_code  (cmd_code),
    .in_ready  (in_ready),
    .acc       (acc)
  );

  icseq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc     (acc),
    .op_done (op_done),
    .par_err (par_err),
    .ack     (ack),
    .state_o (state),
    .code_o  (stat_code),
    .abort_o (abort)
  );

  always_comb begin
    in_ready       = (state == ST_READY);
    running        = (state == ST_BUSY);
    inc_v[IX_PAR]  = running && par_err;
    inc_v[IX_OVR]  = running && overrun;
  end

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    icseq_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (acc.mclr),
      .inc   (inc_v[gi]),
      .cnt_o (cnt_v[gi])
    );
  end

  always_comb begin
    rsp_v_d    = acc.sreq_par || acc.sreq_err;
    rsp_data_d = acc.sreq_par ? {{PAD_W{1'b0}}, cnt_v[IX_PAR]}
                              : {{PAD_W{1'b0}}, cnt_v[IX_OVR]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      prot_r      <= '0;
    end else begin
      rsp_valid_q <= rsp_v_d;
      if (rsp_v_d)     rsp_data_q <= rsp_data_d;
      if (acc.setprot) prot_r     <= cmd_arg;
    end
  end

  assign fn_rdy    = in_ready;
  assign irq       = (state == ST_IRQ);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign prot_q    = prot_r;
endmodule

// File: rtl/icseq_chk.sv
module icseq_chk
  import icseq_pkg::*;
#(
  parameter int PROT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_force,
  input logic [3:0]        cmd_code,
  input logic              ack,
  input logic              fn_rdy,
  input logic              irq,
  input logic [1:0]        stat_code,
  input logic              abort,
  input logic              rsp_valid,
  input logic [PROT_W-1:0] prot_q
);
  logic forced;
  assign forced = cmd_valid && cmd_force;

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn_rdy && irq));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> irq);

  assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack && !forced |=> fn_rdy && !irq);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack && !forced |=> irq && $stable(stat_code));

  assert_sreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rdy && cmd_valid && (cmd_code == CMD_SREQ_PAR || cmd_code == CMD_SREQ_ERR)
    |=> rsp_valid && fn_rdy && !irq);

  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fn_rdy && cmd_valid && !cmd_force |=> !rsp_valid);

  assert_prot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn_rdy && cmd_valid && cmd_code == CMD_SETPROT) |=> $stable(prot_q));

  assert_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && forced && cmd_code == CMD_TERM |=> irq && stat_code == STAT_TERM);
endmodule

bind icseq_top icseq_chk #(.PROT_W(PROT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_force (cmd_force),
  .cmd_code  (cmd_code),
  .ack       (ack),
  .fn_rdy    (fn_rdy),
  .irq       (irq),
  .stat_code (stat_code),
  .abort     (abort),
  .rsp_valid (rsp_valid),
  .prot_q    (prot_q)
);

// File: tb/icseq_top_tb_top.sv
`timescale 1ns/1ps
module icseq_top_tb_top;
  localparam int CNT_W  = 4;
  localparam int PROT_W = 8;
  localparam int DATA_W = 16;
  localparam int NVEC   = 9;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid, cmd_force;
  logic [3:0]        cmd_code;
  logic [PROT_W-1:0] cmd_arg;
  logic              op_done, par_err, overrun, ack;
  logic              fn_rdy, irq, abort, rsp_valid;
  logic [1:0]        stat_code;
  logic [DATA_W-1:0] rsp_data;
  logic [PROT_W-1:0] prot_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  icseq_top #(.CNT_W(CNT_W), .PROT_W(PROT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_force(cmd_force),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .op_done(op_done), .par_err(par_err),
    .overrun(overrun), .ack(ack), .fn_rdy(fn_rdy), .irq(irq), .stat_code(stat_code),
    .abort(abort), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .prot_q(prot_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // code, arg, irq, stat, rsp_valid, rsp_data, prot
  localparam logic [39:0] VEC [NVEC] = '{
    {4'h5, 8'h00, 1'b0, 2'b00, 1'b1, 16'h0000, 8'h00},
    {4'h7, 8'h5A, 1'b1, 2'b00, 1'b0, 16'h0000, 8'h5A},
    {4'h6, 8'h00, 1'b0, 2'b00, 1'b1, 16'h0000, 8'h5A},
    {4'h0, 8'hFF, 1'b0, 2'b00, 1'b0, 16'h0000, 8'h5A},
    {4'h9, 8'hFF, 1'b0, 2'b00, 1'b0, 16'h0000, 8'h5A},
    {4'h3, 8'h00, 1'b1, 2'b00, 1'b0, 16'h0000, 8'h5A},
    {4'h4, 8'h00, 1'b1, 2'b10, 1'b0, 16'h0000, 8'h5A},
    {4'h7, 8'h3C, 1'b1, 2'b00, 1'b0, 16'h0000, 8'h3C},
    {4'h7, 8'h5A, 1'b1, 2'b00, 1'b0, 16'h0000, 8'h5A}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code, input logic frc, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_force = frc; cmd_code = code; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_force = 1'b0; cmd_code = 4'h0; cmd_arg = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic pulse_err(input int npar, input int novr);
    for (int i = 0; i < (npar > novr ? npar : novr); i++) begin
      @(negedge clk);
      par_err = (i < npar); overrun = (i < novr);
    end
    @(negedge clk); par_err = 1'b0; overrun = 1'b0;
  endtask

  task automatic read_counts(input int exp_par, input int exp_ovr, input string req);
    issue(4'h5, 1'b0, 8'h00);
    chk({req, " parity count rsp_valid"}, rsp_valid, 1);
    chk({req, " parity count"}, rsp_data, exp_par);
    issue(4'h6, 1'b0, 8'h00);
    chk({req, " overrun count rsp_valid"}, rsp_valid, 1);
    chk({req, " overrun count"}, rsp_data, exp_ovr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    cmd_valid = 0; cmd_force = 0; cmd_code = 0; cmd_arg = 0;
    op_done = 0; par_err = 0; overrun = 0; ack = 0; rst_n = 0;
    @(negedge clk);
    chk("R1 fn_rdy in reset", fn_rdy, 1);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 fn_rdy", fn_rdy, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 abort", abort, 0);
    chk("R1 prot_q", prot_q, 0);

    // table walk: R2 R6 R7 R8 R10 from ready
    for (int v = 0; v < NVEC; v++) begin
      logic [39:0] e;
      e = VEC[v];
      issue(e[39:36], 1'b0, e[35:28]);
      chk($sformatf("R2/R8/R10 vec%0d irq", v), irq, e[27]);
      chk($sformatf("R11 vec%0d fn_rdy", v), fn_rdy, !e[27]);
      chk($sformatf("R8 vec%0d rsp_valid", v), rsp_valid, e[24]);
      if (e[24]) chk($sformatf("R8 vec%0d rsp_data", v), rsp_data, e[23:8]);
      if (e[27]) chk($sformatf("R6/R7 vec%0d stat_code", v), stat_code, e[26:25]);
      chk($sformatf("R10 vec%0d prot_q", v), prot_q, e[7:0]);
      if (e[27]) begin
        pulse_ack();
        chk($sformatf("R4 vec%0d back to ready", v), fn_rdy && !irq, 1);
      end
    end

    // R3 read with errors, R2 ignored while busy
    issue(4'h1, 1'b0, 8'h00);
    chk("R3 busy drops fn_rdy", fn_rdy, 0);
    chk("R3 busy no irq", irq, 0);
    issue(4'h6, 1'b0, 8'h00);
    chk("R2 unforced request while busy", rsp_valid, 0);
    issue(4'h3, 1'b0, 8'h00);
    chk("R2 unforced clear while busy irq", irq, 0);
    chk("R2 unforced clear while busy abort", abort, 0);
    pulse_err(2, 3);
    pulse_done();
    chk("R3 parity completion irq", irq, 1);
    chk("R3 parity completion code", stat_code, 2'b01);
    chk("R11 no abort on completion", abort, 0);
    repeat (3) @(negedge clk);
    chk("R5 code held", stat_code, 2'b01);
    chk("R5 irq held", irq, 1);
    pulse_ack();
    chk("R4 ack clears irq", irq, 0);
    chk("R4 ack raises fn_rdy", fn_rdy, 1);
    read_counts(2, 3, "R9");

    // R3 write without errors
    issue(4'h2, 1'b0, 8'h00);
    pulse_done();
    chk("R3 normal completion code", stat_code, 2'b00);
    chk("R3 normal completion irq", irq, 1);
    pulse_ack();

    // R7 forced terminate while busy
    issue(4'h1, 1'b0, 8'h00);
    pulse_err(1, 0);
    issue(4'h4, 1'b1, 8'h00);
    chk("R7 terminate irq", irq, 1);
    chk("R7 terminate code", stat_code, 2'b10);
    chk("R11 abort pulse", abort, 1);
    @(negedge clk);
    chk("R11 abort one cycle", abort, 0);
    pulse_ack();
    read_counts(3, 3, "R7 kept");

    // R4 ack and done while ready ignored
    pulse_ack();
    chk("R4 stray ack fn_rdy", fn_rdy, 1);
    chk("R4 stray ack irq", irq, 0);
    pulse_done();
    chk("R3 stray done irq", irq, 0);

    // R6 forced master clear while busy
    issue(4'h1, 1'b0, 8'h00);
    issue(4'h3, 1'b1, 8'h00);
    chk("R6 clear irq", irq, 1);
    chk("R6 clear code", stat_code, 2'b00);
    chk("R6 abort", abort, 1);
    pulse_ack();
    read_counts(0, 0, "R6 cleared");
    chk("R6 prot kept", prot_q, 8'h5A);

    // R7 forced terminate during interrupt
    issue(4'h2, 1'b0, 8'h00);
    pulse_done();
    chk("R7 pre code", stat_code, 2'b00);
    issue(4'h4, 1'b1, 8'h00);
    chk("R7 replaced code", stat_code, 2'b10);
    chk("R7 irq stays", irq, 1);
    chk("R11 no abort in irq", abort, 0);
    pulse_ack();

    // R9 saturation
    issue(4'h1, 1'b0, 8'h00);
    pulse_err(17, 20);
    pulse_done();
    pulse_ack();
    read_counts(15, 15, "R9 saturate");

    // R2 forced non-clear command ignored
    issue(4'h1, 1'b0, 8'h00);
    issue(4'h7, 1'b1, 8'h11);
    chk("R2 forced setprot ignored prot", prot_q, 8'h5A);
    chk("R2 forced setprot ignored busy", fn_rdy, 0);
    chk("R2 forced setprot ignored irq", irq, 0);

    // R1 reset mid instruction
    do_reset();
    chk("R1 reset fn_rdy", fn_rdy, 1);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset prot", prot_q, 0);
    read_counts(0, 0, "R1 reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule